// File: doc/BRIEF.md
# ECC Chunk Status Accumulator

This block condenses the per-chunk status codes that an error-correction engine writes after decoding a page into a single page verdict. A stream of 8-bit status codes arrives one per cycle under a valid strobe. Each code is sorted into one of four classes: clean, erased, uncorrectable, or a count of corrected bits. Running page totals are kept as each code arrives.

A start-of-page pulse opens a new page. A last marker on the final chunk closes it. One cycle after the closing chunk is accepted, a registered result appears with a one-cycle done pulse. The result holds four items: the largest single-chunk bit-flip count, the sum of all corrected bits, the number of uncorrectable chunks, and a page-failed flag. When the page has failed, the largest-flip field reads zero, so the failure takes the place of the maximum. The result holds until the next page closes.

Top module: `ecc_chunk_tally`

## Requirements
- R1: While reset is held, and on the first cycle after it, done is 0 and all result fields are 0.
- R2: A code of 0x00 adds nothing to the total and leaves the running maximum and the failure count unchanged.
- R3: A code of 0xFF (erased chunk) counts neither toward the corrected total, nor the maximum, nor the failure count.
- R4: A code of 0xFE, or any code from 41 (0x29) up to 0xFE, counts as one uncorrectable chunk in the failure count. Code 40 is still a correctable count.
- R5: A code from 1 to 40 is added to the corrected total and raises the running maximum when it is larger.
- R6: If a page holds at least one uncorrectable chunk, the page-failed flag is 1 and the maximum field reads 0. Otherwise the flag is 0 and the field holds the page maximum.
- R7: A start-of-page pulse clears the maximum, the total and the failure count. A chunk accepted in the same cycle as the pulse counts as the first chunk of the new page.
- R8: Done is high for exactly one cycle, in the cycle after a chunk marked last is accepted. The result fields change only at that point and otherwise hold.
- R9: The corrected total holds 16 chunks of 40 bits each (640) without overflow. The failure count holds 16.
- R10: While valid is low, the code and last inputs have no effect on the running totals or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| page_start_i | input | 1 | Clears the running page totals |
| stat_valid_i | input | 1 | A status code is presented this cycle |
| stat_code_i | input | 8 | Per-chunk status code |
| stat_last_i | input | 1 | This chunk closes the page (qualified by valid) |
| res_done_o | output | 1 | One-cycle pulse: the result fields are new |
| res_max_flips_o | output | 6 | Largest corrected count in one chunk; 0 when the page failed |
| res_corr_total_o | output | 10 | Sum of corrected bits over the page |
| res_fail_cnt_o | output | 5 | Number of uncorrectable chunks in the page |
| res_page_fail_o | output | 1 | At least one chunk of the page was uncorrectable |

## Verification
The assertions check on every cycle that the done pulse follows a last chunk by exactly one cycle and at no other time. They also check that the result fields hold between pages, that the maximum never exceeds 40 and is zeroed on a failed page, and that a lone 0xFE closing chunk fails its page. The arithmetic across many chunks can only be shown by the bench's scenarios: the summed total at the 640 boundary, the 40/41 class edge, erased and clean codes mixed among corrected ones, and a start pulse that coincides with a chunk. Those scenarios compare each page's result with totals the bench computes from the class rules.

// File: rtl/ecc_tally_pkg.sv
// Package: shared class type for the chunk status accumulator.
// Assumes nothing beyond the status code classes named here.
package ecc_tally_pkg;
    typedef enum logic [1:0] {
        CLS_CLEAN  = 2'd0,
        CLS_ERASED = 2'd1,
        CLS_UNCORR = 2'd2,
        CLS_FIXED  = 2'd3
    } chunk_cls_t;
endpackage

// File: rtl/ecc_stat_classify.sv
// Module: ecc_stat_classify
// Sorts one status code into a class and yields its bit-flip count.
// Assumes CORR_LIMIT is below both special codes.
module ecc_stat_classify
    import ecc_tally_pkg::*;
#(
    parameter int STAT_W      = 8,
    parameter int CORR_LIMIT  = 40,
    parameter int MAXF_W      = 6,
    parameter logic [STAT_W-1:0] ERASED_CODE = 8'hFF,
    parameter logic [STAT_W-1:0] UNCORR_CODE = 8'hFE
) (
    input  logic [STAT_W-1:0] code_i,
    output chunk_cls_t        cls_o,
    output logic [MAXF_W-1:0] flips_o
);
    localparam logic [STAT_W-1:0] LIMIT_V = STAT_W'(CORR_LIMIT);

    // Pick the class; the special codes win over the range test.
    always_comb begin
        if (code_i == '0)
            cls_o = CLS_CLEAN;
        else if (code_i == ERASED_CODE)
            cls_o = CLS_ERASED;
        else if (code_i == UNCORR_CODE || code_i > LIMIT_V)
            cls_o = CLS_UNCORR;
        else
            cls_o = CLS_FIXED;
    end

    // Only a corrected chunk carries a flip count.
    always_comb begin
        flips_o = (cls_o == CLS_FIXED) ? code_i[MAXF_W-1:0] : '0;
    end
endmodule

// File: rtl/ecc_page_accum.sv
// Module: ecc_page_accum
// Holds the running page maximum, corrected total and failure count.
// The next-state values are also driven out so that a result stage can
// capture them on the chunk that closes the page.
// Assumes at most MAX_CHUNKS chunks between two start pulses.
module ecc_page_accum
    import ecc_tally_pkg::*;
#(
    parameter int MAXF_W = 6,
    parameter int SUM_W  = 10,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              take_i,
    input  chunk_cls_t        cls_i,
    input  logic [MAXF_W-1:0] flips_i,
    output logic [MAXF_W-1:0] nxt_max_o,
    output logic [SUM_W-1:0]  nxt_sum_o,
    output logic [CNT_W-1:0]  nxt_fail_o
);
    logic [MAXF_W-1:0] acc_max;
    logic [SUM_W-1:0]  acc_sum;
    logic [CNT_W-1:0]  acc_fail;
    logic [MAXF_W-1:0] base_max;
    logic [SUM_W-1:0]  base_sum;
    logic [CNT_W-1:0]  base_fail;

    // Start from zero when a new page opens in this cycle.
    always_comb begin
        base_max  = clear_i ? '0 : acc_max;
        base_sum  = clear_i ? '0 : acc_sum;
        base_fail = clear_i ? '0 : acc_fail;
    end

    // Fold the accepted chunk into the totals according to its class.
    always_comb begin
        nxt_max_o  = base_max;
        nxt_sum_o  = base_sum;
        nxt_fail_o = base_fail;
        if (take_i) begin
            unique case (cls_i)
                CLS_FIXED: begin
                    nxt_sum_o = base_sum + SUM_W'(flips_i);
                    if (flips_i > base_max)
                        nxt_max_o = flips_i;
                end
                CLS_UNCORR: nxt_fail_o = base_fail + CNT_W'(1);
                default: ;
            endcase
        end
    end

    // Keep the running totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_max  <= '0;
            acc_sum  <= '0;
            acc_fail <= '0;
        end else begin
            acc_max  <= nxt_max_o;
            acc_sum  <= nxt_sum_o;
            acc_fail <= nxt_fail_o;
        end
    end
endmodule

// File: rtl/ecc_result_stage.sv
// Module: ecc_result_stage
// Registers the page verdict when the closing chunk is accepted and
// pulses done for one cycle. A failed page reports zero as its maximum.
module ecc_result_stage #(
    parameter int MAXF_W = 6,
    parameter int SUM_W  = 10,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close_i,
    input  logic [MAXF_W-1:0] max_i,
    input  logic [SUM_W-1:0]  sum_i,
    input  logic [CNT_W-1:0]  fail_i,
    output logic              done_o,
    output logic [MAXF_W-1:0] max_o,
    output logic [SUM_W-1:0]  sum_o,
    output logic [CNT_W-1:0]  fail_o,
    output logic              page_fail_o
);
    logic any_fail;

    // A single uncorrectable chunk fails the page.
    always_comb any_fail = (fail_i != '0);

    // Capture the verdict on the closing chunk; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            max_o       <= '0;
            sum_o       <= '0;
            fail_o      <= '0;
            page_fail_o <= 1'b0;
        end else begin
            done_o <= close_i;
            if (close_i) begin
                max_o       <= any_fail ? '0 : max_i;
                sum_o       <= sum_i;
                fail_o      <= fail_i;
                page_fail_o <= any_fail;
            end
        end
    end
endmodule

// File: rtl/ecc_chunk_tally.sv
// Module: ecc_chunk_tally (top)
// Turns a stream of per-chunk ECC status codes into a page result.
// Assumes at most MAX_CHUNKS chunks per page and a code stream where
// last is only meaningful together with valid.
module ecc_chunk_tally
    import ecc_tally_pkg::*;
#(
    parameter int STAT_W     = 8,
    parameter int MAX_CHUNKS = 16,
    parameter int CORR_LIMIT = 40,
    parameter int MAXF_W     = $clog2(CORR_LIMIT + 1),
    parameter int SUM_W      = $clog2(MAX_CHUNKS * CORR_LIMIT + 1),
    parameter int CNT_W      = $clog2(MAX_CHUNKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_start_i,
    input  logic              stat_valid_i,
    input  logic [STAT_W-1:0] stat_code_i,
    input  logic              stat_last_i,
    output logic              res_done_o,
    output logic [MAXF_W-1:0] res_max_flips_o,
    output logic [SUM_W-1:0]  res_corr_total_o,
    output logic [CNT_W-1:0]  res_fail_cnt_o,
    output logic              res_page_fail_o
);
    chunk_cls_t        cls;
    logic [MAXF_W-1:0] flips;
    logic [MAXF_W-1:0] nxt_max;
    logic [SUM_W-1:0]  nxt_sum;
    logic [CNT_W-1:0]  nxt_fail;
    logic              close_page;

    // A page closes only on a valid chunk that carries the last marker.
    always_comb close_page = stat_valid_i && stat_last_i;

    ecc_stat_classify #(
        .STAT_W     (STAT_W),
        .CORR_LIMIT (CORR_LIMIT),
        .MAXF_W     (MAXF_W)
    ) classify_i (
        .code_i  (stat_code_i),
        .cls_o   (cls),
        .flips_o (flips)
    );

    ecc_page_accum #(
        .MAXF_W (MAXF_W),
        .SUM_W  (SUM_W),
        .CNT_W  (CNT_W)
    ) accum_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (page_start_i),
        .take_i     (stat_valid_i),
        .cls_i      (cls),
        .flips_i    (flips),
        .nxt_max_o  (nxt_max),
        .nxt_sum_o  (nxt_sum),
        .nxt_fail_o (nxt_fail)
    );

    ecc_result_stage #(
        .MAXF_W (MAXF_W),
        .SUM_W  (SUM_W),
        .CNT_W  (CNT_W)
    ) result_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .close_i     (close_page),
        .max_i       (nxt_max),
        .sum_i       (nxt_sum),
        .fail_i      (nxt_fail),
        .done_o      (res_done_o),
        .max_o       (res_max_flips_o),
        .sum_o       (res_corr_total_o),
        .fail_o      (res_fail_cnt_o),
        .page_fail_o (res_page_fail_o)
    );
endmodule

// File: rtl/ecc_chunk_tally_chk.sv
// Module: ecc_chunk_tally_chk
// Port-level properties of the accumulator, bound to every instance.
module ecc_chunk_tally_chk #(
    parameter int STAT_W     = 8,
    parameter int CORR_LIMIT = 40,
    parameter int MAXF_W     = 6,
    parameter int SUM_W      = 10,
    parameter int CNT_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              page_start_i,
    input logic              stat_valid_i,
    input logic [STAT_W-1:0] stat_code_i,
    input logic              stat_last_i,
    input logic              res_done_o,
    input logic [MAXF_W-1:0] res_max_flips_o,
    input logic [SUM_W-1:0]  res_corr_total_o,
    input logic [CNT_W-1:0]  res_fail_cnt_o,
    input logic              res_page_fail_o
);
    // Done follows a closing chunk by one cycle.
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid_i && stat_last_i) |=> res_done_o);

    // Done never rises without a closing chunk; also covers ignored last (R10).
    assert_no_spurious_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_valid_i && stat_last_i) |=> !res_done_o);

    // Results hold between pages.
    assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_valid_i && stat_last_i) |=> ($stable(res_corr_total_o)
            && $stable(res_fail_cnt_o) && $stable(res_max_flips_o)
            && $stable(res_page_fail_o)));

    // A failed page reports zero as its maximum.
    assert_fail_hides_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_page_fail_o |-> (res_max_flips_o == '0 && res_fail_cnt_o != '0));

    // The maximum never exceeds the correctable limit.
    assert_max_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_max_flips_o <= MAXF_W'(CORR_LIMIT));

    // A fresh single-chunk page with code 0xFE fails.
    assert_lone_uncorr_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (page_start_i && stat_valid_i && stat_last_i && stat_code_i == 8'hFE)
            |=> (res_page_fail_o && res_fail_cnt_o == CNT_W'(1)));

    // A fresh single-chunk erased page reports nothing.
    assert_lone_erased_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (page_start_i && stat_valid_i && stat_last_i && stat_code_i == 8'hFF)
            |=> (res_corr_total_o == '0 && !res_page_fail_o && res_max_flips_o == '0));

    // The total of a passing page is at least its maximum.
    assert_total_covers_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done_o && !res_page_fail_o) |-> (res_corr_total_o >= SUM_W'(res_max_flips_o)));
endmodule

bind ecc_chunk_tally ecc_chunk_tally_chk #(
    .STAT_W     (STAT_W),
    .CORR_LIMIT (CORR_LIMIT),
    .MAXF_W     (MAXF_W),
    .SUM_W      (SUM_W),
    .CNT_W      (CNT_W)
) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .page_start_i     (page_start_i),
    .stat_valid_i     (stat_valid_i),
    .stat_code_i      (stat_code_i),
    .stat_last_i      (stat_last_i),
    .res_done_o       (res_done_o),
    .res_max_flips_o  (res_max_flips_o),
    .res_corr_total_o (res_corr_total_o),
    .res_fail_cnt_o   (res_fail_cnt_o),
    .res_page_fail_o  (res_page_fail_o)
);

// File: tb/ecc_chunk_tally_tb_top.sv
module ecc_chunk_tally_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       page_start_i;
    logic       stat_valid_i;
    logic [7:0] stat_code_i;
    logic       stat_last_i;
    logic       res_done_o;
    logic [5:0] res_max_flips_o;
    logic [9:0] res_corr_total_o;
    logic [4:0] res_fail_cnt_o;
    logic       res_page_fail_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    int m_max, m_sum, m_fail;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_chunk_tally dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .page_start_i     (page_start_i),
        .stat_valid_i     (stat_valid_i),
        .stat_code_i      (stat_code_i),
        .stat_last_i      (stat_last_i),
        .res_done_o       (res_done_o),
        .res_max_flips_o  (res_max_flips_o),
        .res_corr_total_o (res_corr_total_o),
        .res_fail_cnt_o   (res_fail_cnt_o),
        .res_page_fail_o  (res_page_fail_o)
    );

    // Class of a code from the requirements: 0 clean, 1 erased, 2 uncorrectable, 3 corrected.
    function automatic int code_kind(input int code);
        if (code == 0) return 0;
        if (code == 255) return 1;
        if (code == 254 || code > 40) return 2;
        return 3;
    endfunction

    function automatic int pick_code(input int mix);
        int r = $urandom_range(0, 99);
        if (mix == 0) return $urandom_range(0, 40);
        if (r < 10) return 0;
        if (r < 20) return 255;
        if (r < 25) return 254;
        if (r < 30) return $urandom_range(41, 253);
        return $urandom_range(1, 40);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_chunk(input int code, input bit start);
        if (start) begin m_max = 0; m_sum = 0; m_fail = 0; end
        case (code_kind(code))
            2: m_fail++;
            3: begin m_sum += code; if (code > m_max) m_max = code; end
            default: ;
        endcase
    endtask

    task automatic send(input int code, input bit start, input bit last);
        @(negedge clk);
        page_start_i = start;
        stat_valid_i = 1'b1;
        stat_code_i  = code[7:0];
        stat_last_i  = last;
        model_chunk(code, start);
    endtask

    // Sample one cycle after the closing chunk, then confirm done drops.
    task automatic check_result(input string req);
        @(negedge clk);
        page_start_i = 1'b0;
        stat_valid_i = 1'b0;
        stat_last_i  = 1'b0;
        check(res_done_o == 1'b1, {"R8 done ", req}, res_done_o, 1);
        check(res_corr_total_o == m_sum, {"R5 total ", req}, res_corr_total_o, m_sum);
        check(res_fail_cnt_o == m_fail, {"R4 fail count ", req}, res_fail_cnt_o, m_fail);
        check(res_page_fail_o == (m_fail != 0), {"R6 page fail ", req}, res_page_fail_o, m_fail != 0);
        check(res_max_flips_o == ((m_fail != 0) ? 0 : m_max), {"R6 max ", req},
              res_max_flips_o, (m_fail != 0) ? 0 : m_max);
        @(negedge clk);
        check(res_done_o == 1'b0, {"R8 done single cycle ", req}, res_done_o, 0);
    endtask

    task automatic run_page(input int n, input int mix, input string req);
        for (int i = 0; i < n; i++)
            send(pick_code(mix), i == 0, i == n - 1);
        check_result(req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; page_start_i = 1'b0; stat_valid_i = 1'b0;
        stat_code_i = 8'h00; stat_last_i = 1'b0;
        m_max = 0; m_sum = 0; m_fail = 0;
        repeat (3) @(negedge clk);
        check(res_done_o == 0 && res_corr_total_o == 0 && res_fail_cnt_o == 0
              && res_max_flips_o == 0 && !res_page_fail_o, "R1 reset state", res_corr_total_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_done_o == 0 && res_corr_total_o == 0, "R1 after release", res_done_o, 0);

        // R2: clean chunks only
        send(0, 1, 0); send(0, 0, 0); send(0, 0, 1);
        check_result("R2 clean page");
        // R2 + R5: clean codes do not lower a maximum
        send(17, 1, 0); send(0, 0, 0); send(3, 0, 1);
        check_result("R2 clean after flips");
        // R3: erased chunks only, then erased mixed with flips
        send(255, 1, 0); send(255, 0, 1);
        check_result("R3 erased page");
        send(9, 1, 0); send(255, 0, 0); send(2, 0, 1);
        check_result("R3 erased mixed");
        // R4: 40 vs 41 boundary
        send(40, 1, 1);
        check_result("R4 code 40 correctable");
        send(41, 1, 1);
        check_result("R4 code 41 uncorrectable");
        send(5, 1, 0); send(254, 0, 0); send(30, 0, 1);
        check_result("R4 R6 0xFE mid page");
        // R9: full page at the limit, then all uncorrectable
        for (int i = 0; i < 16; i++) send(40, i == 0, i == 15);
        check_result("R9 total 640");
        for (int i = 0; i < 16; i++) send(254, i == 0, i == 15);
        check_result("R9 sixteen failures");
        // R7: abandoned page, restart with a chunk in the same cycle
        send(33, 1, 0); send(254, 0, 0);
        send(4, 1, 0); send(6, 0, 1);
        check_result("R7 restart clears");
        // R10: valid low, code and last toggled, nothing changes
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            stat_valid_i = 1'b0;
            stat_code_i  = 8'($urandom_range(1, 254));
            stat_last_i  = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check(res_done_o == 0 && res_corr_total_o == m_sum,
                  "R10 idle inputs ignored", res_corr_total_o, m_sum);
        end
        stat_last_i = 1'b0;
        // R10: the totals were not touched by the idle codes
        send(1, 0, 1);
        check_result("R10 totals kept across idle");
        // Random pages
        for (int p = 0; p < 60; p++)
            run_page($urandom_range(1, 16), p % 3, "random page");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule